// File: doc/BRIEF.md
# Host Command and Reply Port Block

This block is the host-facing register window of a storage controller. Host software hands the controller work by writing a command's bus address to a request port. It collects finished work by reading completion tags from a reply port. Both ports are backed by first-in first-out queues whose depth is a parameter. On the device side, the command engine drains the request queue through a valid/ready handshake and fills the reply queue through a second valid/ready handshake.

Besides the two ports, the window holds four registers:
- A doorbell word that is driven straight to the device.
- An interrupt mask with inverted sense.
- A read-only interrupt status word.
- A scratchpad that reports firmware readiness.

A single level interrupt output is raised while completions are waiting and the mask allows it. Reads are combinational in the cycle the read strobe is high. A reply-port read removes the returned entry at the next clock edge.

Top module: `hostq_regs`

## Requirements
- R1: A host write to offset 0x40 appends the write data to the request queue. The device side sees the oldest entry on `req_data` while `req_valid` is high, and removes it on a clock edge where `req_valid` and `req_ready` are both high, in order of arrival.
- R2: A host read of offset 0x44 returns the oldest completion tag and removes it at that clock edge. When the reply queue is empty, the read returns 0xFFFFFFFF and changes nothing.
- R3: `rpl_ready` is high exactly while the reply queue holds fewer than DEPTH entries. A push (`rpl_valid` high) while it is low is discarded.
- R4: A host write to offset 0x40 while the request queue holds DEPTH entries is discarded and sets an overflow flag. The flag reads as bit 1 of offset 0x30 and stays set until reset.
- R5: Bit 3 of the status word at offset 0x30 reads 1 exactly while the reply queue is non-empty. All status bits other than 3 and 1 read 0.
- R6: The mask register at offset 0x34 stores bit 3 of the written word and reads it back in bit 3, with all other bits 0. It resets to 1 (interrupt masked). Writing 0 clears it.
- R7: `irq` is high exactly while the reply queue is non-empty and the mask bit is 0.
- R8: Offset 0xB0 reads 0xFFFF0000 if `dev_ready` was high at the previous clock edge, and 0 otherwise.
- R9: A host write to offset 0x20 loads the whole word into the doorbell register. The doorbell register drives `doorbell` and reads back at offset 0x20.
- R10: A read of any offset other than 0x20, 0x30, 0x34, 0x44 and 0xB0 returns 0. A host write to 0x30, 0x44, 0xB0 or an unmapped offset leaves every register and queue unchanged.
- R11: After reset the request and reply queues are empty, the doorbell is 0, the overflow flag is 0 and the scratchpad reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Host write strobe |
| bus_rd_en | input | 1 | Host read strobe |
| bus_addr | input | 8 | Host byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid while bus_rd_en is high |
| req_valid | output | 1 | Request queue holds an entry |
| req_ready | input | 1 | Device takes the head request |
| req_data | output | 32 | Oldest command address |
| rpl_valid | input | 1 | Device offers a completion tag |
| rpl_ready | output | 1 | Reply queue can accept a tag |
| rpl_data | input | 32 | Completion tag from the device |
| dev_ready | input | 1 | Device firmware is ready |
| doorbell | output | 32 | Current doorbell word |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with DEPTH set to 4. At that depth both queues reach their full boundary within a handful of host writes or device pushes. This makes the dropped request write, the sticky overflow flag and the deasserted push ready quick to exercise. The same small depth also makes pointer wraparound quick to reach: a fill-and-drain followed by a second pass through the queues crosses it, as does a stretch where a device push and a host reply read land on the same edge.

// File: rtl/hostq_pkg.sv
package hostq_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DOORBELL = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_REQUEST  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_REPLY    = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_SCRATCH  = 8'hB0;

    localparam int PEND_BIT = 3;
    localparam int OVF_BIT  = 1;
    localparam int MASK_BIT = 3;

    localparam logic [DATA_W-1:0] EMPTY_WORD = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] READY_WORD = 32'hFFFF_0000;

    typedef struct packed {
        logic              mask;
        logic              ovf;
        logic              rdy;
        logic [DATA_W-1:0] bell;
    } regs_t;
endpackage

// File: rtl/hostq_fifo.sv
module hostq_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] pop_data_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    assign full_o     = (st_q.cnt == CW'(DEPTH));
    assign empty_o    = (st_q.cnt == '0);
    assign pop_data_o = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            st_d.mem[st_q.wp] = push_data_i;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: occupancy never passes the configured depth
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R1: an accepted push with no pop grows the queue by one
    assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && !pop_i) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R2: a pop on an empty queue leaves it empty
    assert_empty_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> empty_o);
endmodule

// File: rtl/hostq_regfile.sv
module hostq_regfile
    import hostq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en_i,
    input  logic              bus_rd_en_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              req_full_i,
    output logic              req_push_o,
    input  logic              rpl_empty_i,
    input  logic [DATA_W-1:0] rpl_head_i,
    output logic              rpl_pop_o,
    input  logic              dev_ready_i,
    output logic [DATA_W-1:0] doorbell_o,
    output logic              irq_o
);
    regs_t rg_d, rg_q;
    logic  wr_req, wr_mask, wr_bell, rd_reply;

    assign wr_req   = bus_wr_en_i && (bus_addr_i == OFS_REQUEST);
    assign wr_mask  = bus_wr_en_i && (bus_addr_i == OFS_MASK);
    assign wr_bell  = bus_wr_en_i && (bus_addr_i == OFS_DOORBELL);
    assign rd_reply = bus_rd_en_i && (bus_addr_i == OFS_REPLY);

    assign req_push_o = wr_req && !req_full_i;
    assign rpl_pop_o  = rd_reply && !rpl_empty_i;
    assign irq_o      = !rpl_empty_i && !rg_q.mask;
    assign doorbell_o = rg_q.bell;

    always_comb begin
        rg_d     = rg_q;
        rg_d.rdy = dev_ready_i;
        if (wr_req && req_full_i) rg_d.ovf  = 1'b1;
        if (wr_mask)              rg_d.mask = bus_wdata_i[MASK_BIT];
        if (wr_bell)              rg_d.bell = bus_wdata_i;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_en_i) begin
            unique case (bus_addr_i)
                OFS_DOORBELL: bus_rdata_o = rg_q.bell;
                OFS_STATUS: begin
                    bus_rdata_o[PEND_BIT] = !rpl_empty_i;
                    bus_rdata_o[OVF_BIT]  = rg_q.ovf;
                end
                OFS_MASK:    bus_rdata_o[MASK_BIT] = rg_q.mask;
                OFS_REPLY:   bus_rdata_o = rpl_empty_i ? EMPTY_WORD : rpl_head_i;
                OFS_SCRATCH: bus_rdata_o = rg_q.rdy ? READY_WORD : '0;
                default:     bus_rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q      <= '0;
            rg_q.mask <= 1'b1;
        end else begin
            rg_q <= rg_d;
        end
    end

    // R7: interrupt only while the mask bit is clear
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !rg_q.mask);

    // R4: overflow flag is sticky
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rg_q.ovf) |-> rg_q.ovf);

    // R2: empty reply read yields all ones and pops nothing
    assert_empty_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reply && rpl_empty_i) |-> (bus_rdata_o == EMPTY_WORD && !rpl_pop_o));

    // R8: ready pattern only after the device reported ready
    assert_ready_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en_i && bus_addr_i == OFS_SCRATCH && bus_rdata_o != '0) |-> $past(dev_ready_i));

    // R9: doorbell is stable without a write to it
    assert_bell_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_bell |=> $stable(doorbell_o));
endmodule

// File: rtl/hostq_regs.sv
module hostq_regs #(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr_en,
    input  logic        bus_rd_en,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        req_valid,
    input  logic        req_ready,
    output logic [31:0] req_data,
    input  logic        rpl_valid,
    output logic        rpl_ready,
    input  logic [31:0] rpl_data,
    input  logic        dev_ready,
    output logic [31:0] doorbell,
    output logic        irq
);
    import hostq_pkg::*;

    logic              req_push, req_full, req_empty;
    logic              rpl_pop, rpl_full, rpl_empty;
    logic [DATA_W-1:0] rpl_head;

    assign req_valid = !req_empty;
    assign rpl_ready = !rpl_full;

    hostq_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_req_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (req_push),
        .push_data_i (bus_wdata),
        .pop_i       (req_ready),
        .pop_data_o  (req_data),
        .full_o      (req_full),
        .empty_o     (req_empty)
    );

    hostq_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_rpl_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (rpl_valid),
        .push_data_i (rpl_data),
        .pop_i       (rpl_pop),
        .pop_data_o  (rpl_head),
        .full_o      (rpl_full),
        .empty_o     (rpl_empty)
    );

    hostq_regfile u_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_en_i (bus_wr_en),
        .bus_rd_en_i (bus_rd_en),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .req_full_i  (req_full),
        .req_push_o  (req_push),
        .rpl_empty_i (rpl_empty),
        .rpl_head_i  (rpl_head),
        .rpl_pop_o   (rpl_pop),
        .dev_ready_i (dev_ready),
        .doorbell_o  (doorbell),
        .irq_o       (irq)
    );

    // R3: push ready is low exactly when the reply queue is full
    assert_push_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rpl_valid && !rpl_ready && !rpl_pop) |=> !rpl_ready);
endmodule

// File: tb/hostq_regs_bench.sv
`timescale 1ns/1ps
module hostq_regs_bench;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid, req_ready = 1'b0;
    logic [31:0] req_data;
    logic        rpl_valid = 1'b0, rpl_ready;
    logic [31:0] rpl_data = '0;
    logic        dev_ready = 1'b0;
    logic [31:0] doorbell;
    logic        irq;

    always #10 clk = ~clk;

    hostq_regs #(.DEPTH(D)) u_hostq_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .rpl_valid(rpl_valid), .rpl_ready(rpl_ready), .rpl_data(rpl_data),
        .dev_ready(dev_ready), .doorbell(doorbell), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] reqq[$];
    logic [31:0] rplq[$];
    bit          m_mask = 1'b1, m_ovf = 1'b0, m_rdy = 1'b0;
    logic [31:0] m_bell = '0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        logic [31:0] v = '0;
        case (a)
            8'h20: v = m_bell;
            8'h30: begin v[3] = (rplq.size() > 0); v[1] = m_ovf; end
            8'h34: v[3] = m_mask;
            8'h44: v = (rplq.size() > 0) ? rplq[0] : 32'hFFFF_FFFF;
            8'hB0: v = m_rdy ? 32'hFFFF_0000 : 32'h0;
            default: v = '0;
        endcase
        return v;
    endfunction

    // compare outputs, take one edge, update the model, release strobes
    task automatic tick(string tag);
        int nreq, nrpl;
        #2;
        chk("R7", {31'b0, irq}, {31'b0, (rplq.size() > 0) && !m_mask});
        chk("R3", {31'b0, rpl_ready}, {31'b0, rplq.size() < D});
        chk("R1", {31'b0, req_valid}, {31'b0, reqq.size() > 0});
        if (reqq.size() > 0) chk("R1", req_data, reqq[0]);
        chk("R9", doorbell, m_bell);
        if (bus_rd_en) chk(tag, bus_rdata, exp_rd(bus_addr));
        @(posedge clk);
        nreq = reqq.size();
        nrpl = rplq.size();
        if (bus_wr_en) begin
            case (bus_addr)
                8'h40: if (nreq < D) reqq.push_back(bus_wdata); else m_ovf = 1'b1;
                8'h34: m_mask = bus_wdata[3];
                8'h20: m_bell = bus_wdata;
                default: ;
            endcase
        end
        if (req_ready && nreq > 0) void'(reqq.pop_front());
        if (bus_rd_en && bus_addr == 8'h44 && nrpl > 0) void'(rplq.pop_front());
        if (rpl_valid && nrpl < D) rplq.push_back(rpl_data);
        m_rdy = dev_ready;
        @(negedge clk);
        bus_wr_en = 1'b0;
        bus_rd_en = 1'b0;
        req_ready = 1'b0;
        rpl_valid = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] v, string tag);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = v;
        tick(tag);
    endtask

    task automatic rd(logic [7:0] a, string tag);
        bus_rd_en = 1'b1; bus_addr = a;
        tick(tag);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(8'h30, "R11");
        rd(8'h34, "R6");
        rd(8'h20, "R11");
        rd(8'hB0, "R11");
        rd(8'h44, "R11");

        // R9 doorbell
        wr(8'h20, 32'hA5A5_0F0F, "R9");
        rd(8'h20, "R9");
        wr(8'h20, 32'h0000_0001, "R9");
        rd(8'h20, "R9");

        // R8 ready indication
        dev_ready = 1'b1;
        tick("R8");
        rd(8'hB0, "R8");
        dev_ready = 1'b0;
        rd(8'hB0, "R8");
        rd(8'hB0, "R8");

        // R1 requests in order, device drains
        wr(8'h40, 32'h1000_0000, "R1");
        wr(8'h40, 32'h1000_0040, "R1");
        wr(8'h40, 32'h1000_0080, "R1");
        repeat (4) begin req_ready = 1'b1; tick("R1"); end

        // R4 overflow: six writes into a depth of four
        for (int i = 0; i < 6; i++) wr(8'h40, 32'h2000_0000 + i, "R4");
        rd(8'h30, "R4");
        repeat (5) begin req_ready = 1'b1; tick("R4"); end
        rd(8'h30, "R4");
        // write and pop together at the full boundary
        for (int i = 0; i < 4; i++) wr(8'h40, 32'h3000_0000 + i, "R1");
        req_ready = 1'b1; bus_wr_en = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h3000_0099;
        tick("R4");
        repeat (4) begin req_ready = 1'b1; tick("R1"); end

        // R3/R5/R7 replies fill while masked
        for (int i = 0; i < 6; i++) begin
            rpl_valid = 1'b1; rpl_data = 32'hC000_0000 + i; tick("R3");
        end
        rd(8'h30, "R5");
        wr(8'h34, 32'h0000_0000, "R6");
        rd(8'h34, "R6");
        tick("R7");
        // read and push on the same edge while full
        rpl_valid = 1'b1; rpl_data = 32'hDEAD_0001; bus_rd_en = 1'b1; bus_addr = 8'h44;
        tick("R2");
        rpl_valid = 1'b1; rpl_data = 32'hDEAD_0002; bus_rd_en = 1'b1; bus_addr = 8'h44;
        tick("R2");
        for (int i = 0; i < 5; i++) rd(8'h44, "R2");
        rd(8'h30, "R5");
        rd(8'h44, "R2");
        // re-mask with a pending completion
        rpl_valid = 1'b1; rpl_data = 32'hBEEF_0000; tick("R5");
        wr(8'h34, 32'hFFFF_FFFF, "R6");
        rd(8'h34, "R6");
        tick("R7");
        wr(8'h34, 32'h0000_0008, "R6");
        rd(8'h44, "R2");

        // R10 read-only and unmapped offsets
        rpl_valid = 1'b1; rpl_data = 32'h7777_0000; tick("R10");
        wr(8'h30, 32'hFFFF_FFFF, "R10");
        wr(8'hB0, 32'h0, "R10");
        wr(8'h44, 32'h1234_5678, "R10");
        wr(8'h10, 32'hFFFF_FFFF, "R10");
        rd(8'h30, "R10");
        rd(8'h20, "R10");
        rd(8'h10, "R10");
        rd(8'h40, "R10");
        rd(8'hFC, "R10");
        rd(8'h44, "R10");
        rd(8'h44, "R2");

        summary();
    end
endmodule